// File: doc/BRIEF.md
# Select-Release Receive Count Capture

This unit sits next to a two-buffer receive DMA engine on the slave side of an SPI link. It watches the slave-select line, which is active low and already synchronized to the block clock. When select is released (the line goes from low to high), it stores the byte count of the receive buffer in use at that moment. This lets software see how much of a buffer the last transfer filled. A 3-bit status word tells which buffer the stored count came from, and whether select was released again after that.

Only the first release after a buffer is loaded stores a count. Later releases leave the stored count alone and only raise a flag in the status word. Loading either buffer re-arms the capture. Every pin is a plain control or status level. No data stream crosses the edge of the block, so there is no valid/ready handshake and no back-pressure. The count inputs are sampled in the cycle of the release and have no handshake of their own.

Top module: `ssc_rx_count_capture`

## Requirements
- R1: While `rst_n` is low and after reset, `saved_count` is 0 and `cap_status` is 3'b000.
- R2: A release is `sel_n_sync` being 0 in one cycle and 1 in the next. If capture is armed, a release copies `count_a` (when `active_buf` is 0) or `count_b` (when `active_buf` is 1) into `saved_count`. The new value is visible after the clock edge that ends the release cycle.
- R3: A capture sets `cap_status` to 3'b001 when the count came from buffer A and to 3'b010 when it came from buffer B. Bits 1:0 never both read 1.
- R4: A capture disarms. Later releases leave `saved_count` unchanged until the next load.
- R5: A release that does not capture sets `cap_status` bit 2, but only while bit 0 or bit 1 is already set. Bit 2 is never 1 while bits 1:0 are 00.
- R6: A release while capture is not armed and bits 1:0 are 00 changes neither output.
- R7: `load_a` or `load_b` high for one cycle arms capture and clears `cap_status` to 3'b000. It leaves `saved_count` unchanged.
- R8: `stat_clr` clears `cap_status` to 3'b000. It does not arm capture and keeps `saved_count`. If it falls in the same cycle as a release, the clear acts first, so a release that does not capture leaves bit 2 at 0.
- R9: If a load and a release fall in the same cycle, the load acts first, and that release captures as in R2 and R3.
- R10: Edges are found from a registered copy of `sel_n_sync`, which resets to 1. Holding select high from reset, holding it at any steady level, or driving it low never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n_sync | input | 1 | Synchronized slave select, active low |
| active_buf | input | 1 | Buffer the DMA engine is filling: 0 for A, 1 for B |
| count_a | input | CNT_W | Byte count of buffer A |
| count_b | input | CNT_W | Byte count of buffer B |
| load_a | input | 1 | One-cycle strobe: buffer A was loaded |
| load_b | input | 1 | One-cycle strobe: buffer B was loaded |
| stat_clr | input | 1 | One-cycle strobe: clear the status word |
| saved_count | output | CNT_W | Count stored at the first release after a load |
| cap_status | output | 3 | Bit 0: saved from A; bit 1: saved from B; bit 2: another release since the save |

## Verification
Two kinds of same-cycle collision matter here. A buffer load can fall in the same cycle as a select release, and a status clear can fall in the same cycle as a release. The bench sweeps both buffers and both active-buffer settings. For each setting it places the release before, on and after the load or clear cycle, then follows with zero, one or two extra releases. A reference model in the bench applies the load or clear first and then the edge. The outputs are compared after every cycle, so a wrong ordering shows up at once as a missing capture or a stray bit 2.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef struct packed {
    logic extra;
    logic from_b;
    logic from_a;
  } cap_status_t;

  localparam cap_status_t STATUS_NONE = '{extra: 1'b0, from_b: 1'b0, from_a: 1'b0};
endpackage

// File: rtl/ssc_edge_detect.sv
module ssc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_sync,
  output logic release_pulse
);
  logic prev_q;

  // R10: the previous value resets to the released level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sel_n_sync;
  end

  assign release_pulse = sel_n_sync & ~prev_q;

  // R10: two releases can never fall in back-to-back cycles
  assert_no_double_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);
endmodule

// File: rtl/ssc_arm_ctrl.sv
module ssc_arm_ctrl
  import ssc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        release_pulse,
  input  logic        active_buf,
  input  logic        load_a,
  input  logic        load_b,
  input  logic        stat_clr,
  output logic        capture,
  output cap_status_t status
);
  logic        armed_q, armed_d, armed_mid;
  cap_status_t stat_q, stat_d, stat_mid;
  logic        load_any;

  assign load_any = load_a | load_b;

  // Loads and clears act first; the edge then sees the result (R8, R9)
  always_comb begin
    armed_mid = armed_q;
    stat_mid  = stat_q;
    if (load_any) begin
      armed_mid = 1'b1;
      stat_mid  = STATUS_NONE;
    end
    if (stat_clr) stat_mid = STATUS_NONE;

    capture = release_pulse & armed_mid;
    armed_d = armed_mid;
    stat_d  = stat_mid;
    if (capture) begin
      armed_d       = 1'b0;
      stat_d        = STATUS_NONE;
      stat_d.from_a = ~active_buf;
      stat_d.from_b = active_buf;
    end else if (release_pulse && (stat_mid.from_a || stat_mid.from_b)) begin
      stat_d.extra = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      stat_q  <= STATUS_NONE;
    end else begin
      armed_q <= armed_d;
      stat_q  <= stat_d;
    end
  end

  assign status = stat_q;

  assert_source_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status.from_b, status.from_a}));
  assert_extra_needs_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status.extra |-> (status.from_a | status.from_b));
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_any && !release_pulse) |=> (status == STATUS_NONE));
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !load_any && !release_pulse) |=> (status == STATUS_NONE));
  assert_load_then_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_any && release_pulse) |=> ($onehot({status.from_b, status.from_a}) && !status.extra));
endmodule

// File: rtl/ssc_count_hold.sv
module ssc_count_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             active_buf,
  input  logic [CNT_W-1:0] count_a,
  input  logic [CNT_W-1:0] count_b,
  output logic [CNT_W-1:0] saved_count
);
  logic [CNT_W-1:0] picked;

  assign picked = active_buf ? count_b : count_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved_count <= '0;
    else if (capture) saved_count <= picked;
  end

  // R4: without a capture strobe the stored count holds
  assert_hold_without_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(saved_count));
endmodule

// File: rtl/ssc_rx_count_capture.sv
module ssc_rx_count_capture
  import ssc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_sync,
  input  logic             active_buf,
  input  logic [CNT_W-1:0] count_a,
  input  logic [CNT_W-1:0] count_b,
  input  logic             load_a,
  input  logic             load_b,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] saved_count,
  output logic [2:0]       cap_status
);
  logic        release_pulse;
  logic        capture;
  cap_status_t status;

  ssc_edge_detect i_edge (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_n_sync    (sel_n_sync),
    .release_pulse (release_pulse)
  );

  ssc_arm_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .release_pulse (release_pulse),
    .active_buf    (active_buf),
    .load_a        (load_a),
    .load_b        (load_b),
    .stat_clr      (stat_clr),
    .capture       (capture),
    .status        (status)
  );

  ssc_count_hold #(.CNT_W(CNT_W)) i_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture),
    .active_buf  (active_buf),
    .count_a     (count_a),
    .count_b     (count_b),
    .saved_count (saved_count)
  );

  assign cap_status = status;

  // R2: the stored count moves only after a select release
  assert_change_needs_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(release_pulse) |-> $stable(saved_count));
endmodule

// File: tb/test_ssc_rx_count_capture.sv
module test_ssc_rx_count_capture;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b1, abuf = 1'b0, la = 1'b0, lb = 1'b0, clr = 1'b0;
  logic [CW-1:0] ca = '0, cb = '0;
  logic [CW-1:0] saved;
  logic [2:0]    stat;

  int checks = 0, fails = 0;
  bit done = 0;

  logic          m_prev = 1'b1, m_armed = 1'b0;
  logic [2:0]    m_stat = 3'b000;
  logic [CW-1:0] m_saved = '0;

  always #5 clk = ~clk;

  ssc_rx_count_capture #(.CNT_W(CW)) i_ssc_rx_count_capture (
    .clk(clk), .rst_n(rst_n), .sel_n_sync(sel), .active_buf(abuf),
    .count_a(ca), .count_b(cb), .load_a(la), .load_b(lb), .stat_clr(clr),
    .saved_count(saved), .cap_status(stat)
  );

  task automatic check(input string req);
    checks++;
    if (saved !== m_saved || stat !== m_stat) begin
      fails++;
      $display("FAIL %s: saved=%0d status=%b expected saved=%0d status=%b",
               req, saved, stat, m_saved, m_stat);
    end
  endtask

  // One cycle: drive, clock, update the model from the rules, sample 2 ns later
  task automatic step(input logic s, input logic b, input logic l_a, input logic l_b,
                      input logic c, input string req);
    logic rise;
    sel = s; abuf = b; la = l_a; lb = l_b; clr = c;
    @(posedge clk);
    rise = s && !m_prev;
    if (l_a || l_b) begin m_armed = 1'b1; m_stat = 3'b000; end
    if (c) m_stat = 3'b000;
    if (rise) begin
      if (m_armed) begin
        m_saved = b ? cb : ca;
        m_stat  = b ? 3'b010 : 3'b001;
        m_armed = 1'b0;
      end else if (m_stat[1:0] != 2'b00) m_stat[2] = 1'b1;
    end
    m_prev = s;
    #2;
    check(req);
  endtask

  initial begin
    #3;
    checks++;
    if (saved !== '0 || stat !== 3'b000) begin
      fails++; $display("FAIL R1: in reset saved=%0d status=%b expected 0/000", saved, stat);
    end
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    // R10: select held high from reset, then R6: release with nothing armed
    step(1, 0, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 0, "R6");
    for (int b = 0; b < 2; b++)
      for (int which = 0; which < 2; which++)
        for (int mode = 0; mode < 4; mode++)
          for (int extra = 0; extra < 3; extra++) begin
            ca = CW'(17 + b*31 + which*7 + mode*5 + extra);
            cb = CW'(200 - b*13 - mode*3 - extra);
            step(0, b[0], 0, 0, 0, "R10");
            case (mode)
              0: begin // load, idle, then release: R7 and R2
                step(0, b[0], which == 0, which == 1, 0, "R7");
                step(1, b[0], 0, 0, 0, "R2");
              end
              1: begin // load in the release cycle: R9
                step(1, b[0], which == 0, which == 1, 0, "R9");
              end
              2: begin // clear in the release cycle without arming: R8
                step(1, b[0], 0, 0, 1, "R8");
                step(0, b[0], which == 0, which == 1, 0, "R7");
                step(1, b[0], 0, 0, 0, "R3");
              end
              default: begin // load, release, then clear, then release: R8
                step(0, b[0], which == 0, which == 1, 0, "R7");
                step(1, b[0], 0, 0, 0, "R3");
                step(1, b[0], 0, 0, 1, "R8");
                step(0, b[0], 0, 0, 0, "R8");
                step(1, b[0], 0, 0, 1, "R8");
              end
            endcase
            for (int e = 0; e < extra; e++) begin
              ca = ca + 1; cb = cb - 1;
              step(0, ~b[0], 0, 0, 0, "R4");
              step(1, ~b[0], 0, 0, 0, "R5");
            end
            step(1, b[0], 0, 0, 0, "R10");
          end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule